// File: doc/BRIEF.md
# Variable-Length Instruction Byte Fetcher

This block turns a stream of 16-bit instruction words, fetched from memory one word at a time, into a stream of bytes that make up variable-length instructions. Each instruction starts with an opcode byte. A small writable table, indexed by the opcode, says whether the instruction is one, two or three bytes long. The bytes after the opcode are operands: the first is called alpha and the second is called beta.

A PC load picks the starting byte address and throws away anything already buffered. From then on the block fetches words ahead into a short byte queue. A dispatch strobe makes the next opcode the current instruction and shows its PC and opcode. Next-data reads then return the operand bytes in order. Once the operands have all been read, each further read returns the instruction length.

An odd starting address is allowed: only the odd byte of the first word is kept. A mode input swaps which half of a memory word holds the lower byte address.

Top module: `insn_byte_fetch`

## Requirements
- R1: The length table stores a 2-bit code per opcode, written through `len_we_i`/`len_addr_i`/`len_code_i`; codes 1, 2 and 3 give that many instruction bytes, and code 0 is taken as length 1.
- R2: `disp_rdy_o` is high while the opcode byte of the next instruction is held in the queue; a dispatch while it is high shows that opcode on `cur_opcode_o` with `cur_valid_o` high from the following cycle.
- R3: After a dispatch of a 2-byte opcode, the first accepted next-data read returns alpha (the byte at PC+1); for a 3-byte opcode the second accepted read returns beta (the byte at PC+2).
- R4: Once all operand bytes of the current instruction are read, every further next-data read has `nd_valid_o` high and returns the instruction length zero-extended to 8 bits, and keeps returning it on repeated reads.
- R5: `nd_valid_o` is low while the next operand byte has not yet arrived from memory; a read request made while it is low has no effect, and the operand is still returned by the first read after it arrives.
- R6: After loading an odd PC, only the byte at the odd address of the first fetched word is kept, and it is the opcode; the next word supplies that instruction's operand and the following opcode.
- R7: `cur_pc_o` equals the loaded PC for the first dispatched instruction, and equals the previous `cur_pc_o` plus the previous instruction's length for each later one.
- R8: With `hi_first_i` low, bits 7:0 of a fetched word hold the even byte address and bits 15:8 the odd one; with `hi_first_i` high the two halves are swapped.
- R9: `fetch_addr_o` is PC[15:1] after a load and increases by one for each accepted word (`fetch_req_o` and `fetch_ack_i` high together); a request is made only while the queue has room for two more bytes, so with nothing consumed the queue fills to its depth and requests stop.
- R10: Reset or a `halt_i` pulse empties the queue, clears `cur_valid_o`, `disp_rdy_o` and `nd_valid_o`, and keeps `fetch_req_o` low until the next PC load; `halt_i` wins over a load in the same cycle.
- R11: A PC load empties the queue, clears the current instruction, and requests the word at the new word address in the next cycle.
- R12: A dispatch made before all operands are read discards the unread operand bytes, and it takes priority over a next-data read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Flush the queue and stop fetching until the next load |
| pc_load_i | input | 1 | Load a new byte PC |
| pc_val_i | input | PC_W | PC value to load |
| hi_first_i | input | 1 | Byte order: 1 puts the even address in bits 15:8 |
| fetch_req_o | output | 1 | Word fetch request |
| fetch_addr_o | output | PC_W-1 | Word address of the request |
| fetch_ack_i | input | 1 | Memory accepts the request; data is valid this cycle |
| fetch_data_i | input | 16 | Fetched word |
| len_we_i | input | 1 | Length table write enable |
| len_addr_i | input | 8 | Opcode to write |
| len_code_i | input | 2 | Length code (0 means 1) |
| dispatch_i | input | 1 | Advance to the next instruction |
| disp_rdy_o | output | 1 | Next opcode is available |
| cur_valid_o | output | 1 | A current instruction exists |
| cur_opcode_o | output | 8 | Opcode of the current instruction |
| cur_pc_o | output | PC_W | Byte PC of the current instruction |
| nd_req_i | input | 1 | Next-data read request |
| nd_valid_o | output | 1 | Next-data output is valid |
| nd_data_o | output | 8 | Operand byte, or the length once operands are read |

## Verification
`disp_rdy_o`, `nd_valid_o` and `nd_data_o` come only from registers, so they answer in the same cycle as the request. A dispatch, a read, a load or a halt shows its effect after the next rising edge. The fetch address of a load is due one edge after the load, and each accepted word moves it one edge later. The bench changes every input on the falling edge and samples every output on the falling edge. Each result is therefore read half a period after the edge that made it, and the bench waits on `disp_rdy_o` and `nd_valid_o` instead of counting memory latency, since its memory model acks with a varying period.

// File: rtl/insn_byte_fetch_pkg.sv
package insn_byte_fetch_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [1:0]        len_t;

  // length code 0 is taken as a single-byte instruction
  function automatic len_t code_to_len(input len_t code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction

endpackage

// File: rtl/insn_byte_fetch_lenram.sv
module insn_byte_fetch_lenram
  import insn_byte_fetch_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [OPC_W-1:0] waddr_i,
  input  len_t             wcode_i,
  input  logic [OPC_W-1:0] raddr_i,
  output len_t             len_o
);

  localparam int ENTRIES = 1 << OPC_W;

  len_t mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wcode_i;
    end
  end

  assign len_o = code_to_len(mem_q[raddr_i]);

endmodule

// File: rtl/insn_byte_fetch_unpack.sv
module insn_byte_fetch_unpack
  import insn_byte_fetch_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  input  logic              hi_first_i,
  input  logic              skip_even_i,
  output byte_t             b0_o,
  output byte_t             b1_o,
  output logic [1:0]        n_o
);

  byte_t even_b;
  byte_t odd_b;

  always_comb begin
    even_b = hi_first_i ? word_i[15:8] : word_i[7:0];
    odd_b  = hi_first_i ? word_i[7:0]  : word_i[15:8];
    b0_o   = skip_even_i ? odd_b : even_b;
    b1_o   = odd_b;
    if (!take_i)          n_o = 2'd0;
    else if (skip_even_i) n_o = 2'd1;
    else                  n_o = 2'd2;
  end

endmodule

// File: rtl/insn_byte_fetch_queue.sv
module insn_byte_fetch_queue
  import insn_byte_fetch_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic [1:0]             pop_n_i,
  input  logic [1:0]             push_n_i,
  input  byte_t                  push_b0_i,
  input  byte_t                  push_b1_i,
  output logic [DEPTH-1:0][7:0]  bytes_o,
  output logic [CNT_W-1:0]       count_o
);

  logic [DEPTH-1:0][7:0] bytes_q, bytes_d;
  logic [CNT_W-1:0]      count_q, count_d, cnt_mid;
  logic                  data_en;

  always_comb begin
    cnt_mid = count_q - CNT_W'(pop_n_i);
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n_i) < DEPTH) bytes_d[i] = bytes_q[i + int'(pop_n_i)];
      else                           bytes_d[i] = '0;
      if (push_n_i != 2'd0 && i == int'(cnt_mid))      bytes_d[i] = push_b0_i;
      if (push_n_i == 2'd2 && i == int'(cnt_mid) + 1)  bytes_d[i] = push_b1_i;
    end
    count_d = clear_i ? '0 : cnt_mid + CNT_W'(push_n_i);
    data_en = (pop_n_i != 2'd0) || (push_n_i != 2'd0);
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      bytes_q <= bytes_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign bytes_o = bytes_q;
  assign count_o = count_q;

endmodule

// File: rtl/insn_byte_fetch.sv
module insn_byte_fetch
  import insn_byte_fetch_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DEPTH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              pc_load_i,
  input  logic [PC_W-1:0]   pc_val_i,
  input  logic              hi_first_i,
  output logic              fetch_req_o,
  output logic [PC_W-2:0]   fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [15:0]       fetch_data_i,
  input  logic              len_we_i,
  input  logic [7:0]        len_addr_i,
  input  logic [1:0]        len_code_i,
  input  logic              dispatch_i,
  output logic              disp_rdy_o,
  output logic              cur_valid_o,
  output logic [7:0]        cur_opcode_o,
  output logic [PC_W-1:0]   cur_pc_o,
  input  logic              nd_req_i,
  output logic              nd_valid_o,
  output logic [7:0]        nd_data_o
);

  localparam int WA_W  = PC_W - 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // registered state
  logic            active_q, active_d;
  logic            skip_q, skip_d;
  logic [WA_W-1:0] waddr_q, waddr_d;
  logic [1:0]      rem_q, rem_d;
  logic            cur_valid_q, cur_valid_d;
  byte_t           cur_op_q, cur_op_d;
  len_t            cur_len_q, cur_len_d;
  logic [PC_W-1:0] cur_pc_q, cur_pc_d;
  logic [PC_W-1:0] nxt_pc_q, nxt_pc_d;

  // queue and helpers
  logic [DEPTH-1:0][7:0] q_bytes;
  logic [CNT_W-1:0]      q_count;
  logic                  flush;
  logic                  word_acc;
  logic                  disp_go, nd_go;
  logic [1:0]            pop_n, push_n;
  byte_t                 push_b0, push_b1;
  byte_t                 next_op;
  len_t                  next_len;

  assign flush       = halt_i | pc_load_i;
  assign fetch_req_o = active_q && (q_count <= CNT_W'(DEPTH - 2));
  assign word_acc    = fetch_req_o && fetch_ack_i && !flush;
  assign disp_rdy_o  = active_q && (q_count > CNT_W'(rem_q));
  assign nd_valid_o  = cur_valid_q && ((rem_q == 2'd0) || (q_count != '0));
  assign nd_data_o   = (rem_q == 2'd0) ? {6'd0, cur_len_q} : q_bytes[0];
  assign next_op     = q_bytes[rem_q];

  assign disp_go = dispatch_i && disp_rdy_o && !flush;
  assign nd_go   = nd_req_i && nd_valid_o && !disp_go && !flush && (rem_q != 2'd0);
  assign pop_n   = disp_go ? (rem_q + 2'd1) : (nd_go ? 2'd1 : 2'd0);

  insn_byte_fetch_lenram #(.OPC_W(8)) u_lenram (
    .clk     (clk),
    .we_i    (len_we_i),
    .waddr_i (len_addr_i),
    .wcode_i (len_code_i),
    .raddr_i (next_op),
    .len_o   (next_len)
  );

  insn_byte_fetch_unpack u_unpack (
    .word_i      (fetch_data_i),
    .take_i      (word_acc),
    .hi_first_i  (hi_first_i),
    .skip_even_i (skip_q),
    .b0_o        (push_b0),
    .b1_o        (push_b1),
    .n_o         (push_n)
  );

  insn_byte_fetch_queue #(.DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (flush),
    .pop_n_i   (flush ? 2'd0 : pop_n),
    .push_n_i  (push_n),
    .push_b0_i (push_b0),
    .push_b1_i (push_b1),
    .bytes_o   (q_bytes),
    .count_o   (q_count)
  );

  always_comb begin
    active_d    = active_q;
    skip_d      = skip_q;
    waddr_d     = waddr_q;
    rem_d       = rem_q;
    cur_valid_d = cur_valid_q;
    cur_op_d    = cur_op_q;
    cur_len_d   = cur_len_q;
    cur_pc_d    = cur_pc_q;
    nxt_pc_d    = nxt_pc_q;
    if (halt_i) begin
      active_d    = 1'b0;
      cur_valid_d = 1'b0;
      rem_d       = 2'd0;
    end else if (pc_load_i) begin
      active_d    = 1'b1;
      waddr_d     = pc_val_i[PC_W-1:1];
      skip_d      = pc_val_i[0];
      cur_valid_d = 1'b0;
      rem_d       = 2'd0;
      nxt_pc_d    = pc_val_i;
    end else begin
      if (word_acc) begin
        waddr_d = waddr_q + WA_W'(1);
        skip_d  = 1'b0;
      end
      if (disp_go) begin
        cur_valid_d = 1'b1;
        cur_op_d    = next_op;
        cur_len_d   = next_len;
        cur_pc_d    = nxt_pc_q;
        nxt_pc_d    = nxt_pc_q + PC_W'(next_len);
        rem_d       = next_len - 2'd1;
      end else if (nd_go) begin
        rem_d = rem_q - 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      skip_q      <= 1'b0;
      waddr_q     <= '0;
      rem_q       <= 2'd0;
      cur_valid_q <= 1'b0;
      cur_op_q    <= '0;
      cur_len_q   <= 2'd1;
      cur_pc_q    <= '0;
      nxt_pc_q    <= '0;
    end else begin
      active_q    <= active_d;
      skip_q      <= skip_d;
      waddr_q     <= waddr_d;
      rem_q       <= rem_d;
      cur_valid_q <= cur_valid_d;
      cur_op_q    <= cur_op_d;
      cur_len_q   <= cur_len_d;
      cur_pc_q    <= cur_pc_d;
      nxt_pc_q    <= nxt_pc_d;
    end
  end

  assign fetch_addr_o = waddr_q;
  assign cur_valid_o  = cur_valid_q;
  assign cur_opcode_o = cur_op_q;
  assign cur_pc_o     = cur_pc_q;

endmodule

// File: rtl/insn_byte_fetch_chk.sv
module insn_byte_fetch_chk #(
  parameter int PC_W  = 16,
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt_i,
  input logic            pc_load_i,
  input logic [PC_W-1:0] pc_val_i,
  input logic            fetch_req_o,
  input logic            fetch_ack_i,
  input logic [PC_W-2:0] fetch_addr_o,
  input logic            dispatch_i,
  input logic            disp_rdy_o,
  input logic            cur_valid_o,
  input logic [PC_W-1:0] cur_pc_o,
  input logic            nd_req_i,
  input logic            nd_valid_o,
  input logic [7:0]      nd_data_o,
  input logic [1:0]      rem_q,
  input logic [1:0]      cur_len_q,
  input logic [CNT_W-1:0] q_count
);

  p_halt_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (!fetch_req_o && !cur_valid_o && !disp_rdy_o && !nd_valid_o));

  p_load_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_i && !halt_i) |=>
      (!cur_valid_o && fetch_req_o && fetch_addr_o == $past(pc_val_i[PC_W-1:1])));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_o && fetch_ack_i && !halt_i && !pc_load_i) |=>
      (fetch_addr_o == $past(fetch_addr_o) + 1'b1));

  p_queue_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  p_dispatch_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch_i && disp_rdy_o && !halt_i && !pc_load_i) |=> cur_valid_o);

  p_pc_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatch_i && disp_rdy_o && cur_valid_o && !halt_i && !pc_load_i) |=>
      (cur_pc_o == $past(cur_pc_o) + PC_W'($past(cur_len_q))));

  p_len_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_req_i && nd_valid_o && rem_q == 2'd0 && !dispatch_i && !halt_i && !pc_load_i) |=>
      (nd_valid_o && nd_data_o == $past(nd_data_o)));

  p_stall_no_effect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nd_req_i && !nd_valid_o && !dispatch_i && !halt_i && !pc_load_i) |=> $stable(rem_q));

endmodule

bind insn_byte_fetch insn_byte_fetch_chk #(
  .PC_W  (PC_W),
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_i       (halt_i),
  .pc_load_i    (pc_load_i),
  .pc_val_i     (pc_val_i),
  .fetch_req_o  (fetch_req_o),
  .fetch_ack_i  (fetch_ack_i),
  .fetch_addr_o (fetch_addr_o),
  .dispatch_i   (dispatch_i),
  .disp_rdy_o   (disp_rdy_o),
  .cur_valid_o  (cur_valid_o),
  .cur_pc_o     (cur_pc_o),
  .nd_req_i     (nd_req_i),
  .nd_valid_o   (nd_valid_o),
  .nd_data_o    (nd_data_o),
  .rem_q        (rem_q),
  .cur_len_q    (cur_len_q),
  .q_count      (q_count)
);

// File: tb/insn_byte_fetch_bench.sv
module insn_byte_fetch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;

  logic        clk;
  logic        rst_n;
  logic        halt_i;
  logic        pc_load_i;
  logic [15:0] pc_val_i;
  logic        hi_first_i;
  logic        fetch_req_o;
  logic [14:0] fetch_addr_o;
  logic        fetch_ack_i;
  logic [15:0] fetch_data_i;
  logic        len_we_i;
  logic [7:0]  len_addr_i;
  logic [1:0]  len_code_i;
  logic        dispatch_i;
  logic        disp_rdy_o;
  logic        cur_valid_o;
  logic [7:0]  cur_opcode_o;
  logic [15:0] cur_pc_o;
  logic        nd_req_i;
  logic        nd_valid_o;
  logic [7:0]  nd_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int budget = 0;
  int ack_period = 1;
  int cyc = 0;

  insn_byte_fetch #(.PC_W(16), .DEPTH(DEPTH)) u_insn_byte_fetch (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .pc_load_i(pc_load_i),
    .pc_val_i(pc_val_i), .hi_first_i(hi_first_i), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i),
    .len_we_i(len_we_i), .len_addr_i(len_addr_i), .len_code_i(len_code_i),
    .dispatch_i(dispatch_i), .disp_rdy_o(disp_rdy_o), .cur_valid_o(cur_valid_o),
    .cur_opcode_o(cur_opcode_o), .cur_pc_o(cur_pc_o), .nd_req_i(nd_req_i),
    .nd_valid_o(nd_valid_o), .nd_data_o(nd_data_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // program byte at a byte address
  function automatic logic [7:0] bval(input logic [15:0] a);
    logic [15:0] t;
    t = (a * 16'd13) ^ (a >> 3) ^ 16'h005A;
    return t[7:0];
  endfunction

  function automatic logic [1:0] lcode(input logic [7:0] op);
    int x;
    x = (int'(op) * 7 + 3) % 4;
    return x[1:0];
  endfunction

  function automatic int elen(input logic [7:0] op);
    return (lcode(op) == 2'd0) ? 1 : int'(lcode(op));
  endfunction

  // memory model: drives on the falling edge, counts accepted words
  always @(negedge clk) begin
    logic [7:0] ev, od;
    cyc++;
    ev = bval({fetch_addr_o, 1'b0});
    od = bval({fetch_addr_o, 1'b1});
    fetch_data_i = hi_first_i ? {ev, od} : {od, ev};
    fetch_ack_i  = (budget != 0) && (cyc % ack_period == 0);
    #1;
    if (fetch_req_o && fetch_ack_i && budget > 0) budget--;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_pc(input logic [15:0] p);
    pc_val_i  = p;
    pc_load_i = 1'b1;
    @(negedge clk);
    pc_load_i = 1'b0;
  endtask

  task automatic do_dispatch();
    while (!disp_rdy_o) @(negedge clk);
    dispatch_i = 1'b1;
    @(negedge clk);
    dispatch_i = 1'b0;
  endtask

  task automatic nd_read(output logic [7:0] d);
    while (!nd_valid_o) @(negedge clk);
    d = nd_data_o;
    nd_req_i = 1'b1;
    @(negedge clk);
    nd_req_i = 1'b0;
  endtask

  // walk n instructions from p and compare against the byte image
  task automatic run_seq(input logic [15:0] p, input bit hf, input int ap, input int n);
    logic [15:0] pc;
    logic [7:0]  op, d;
    int          len;
    bit          skipped;
    string       tag;
    hi_first_i = hf;
    ack_period = ap;
    budget     = -1;
    load_pc(p);
    chk(cur_valid_o == 1'b0, "R11", int'(cur_valid_o), 0);
    chk(fetch_addr_o == p[15:1], "R11", int'(fetch_addr_o), int'(p[15:1]));
    pc = p;
    skipped = 0;
    for (int k = 0; k < n; k++) begin
      op  = bval(pc);
      len = elen(op);
      do_dispatch();
      if (k == 0 && p[0])  tag = "R6";
      else if (skipped)    tag = "R12";
      else if (hf)         tag = "R8";
      else                 tag = "R2";
      chk(cur_valid_o && cur_opcode_o == op, tag, int'(cur_opcode_o), int'(op));
      chk(cur_pc_o == pc, "R7", int'(cur_pc_o), int'(pc));
      skipped = (k % 3 == 2) && (len > 1);
      if (!skipped) begin
        if (len >= 2) begin
          nd_read(d);
          chk(d == bval(pc + 16'd1), (k == 0 && p[0]) ? "R6" : "R3", int'(d), int'(bval(pc + 16'd1)));
        end
        if (len == 3) begin
          nd_read(d);
          chk(d == bval(pc + 16'd2), "R3", int'(d), int'(bval(pc + 16'd2)));
        end
        for (int r = 0; r < 2; r++) begin
          nd_read(d);
          chk(d == 8'(len), (lcode(op) == 2'd0) ? "R1" : "R4", int'(d), len);
        end
      end
      pc = pc + 16'(len);
    end
  endtask

  initial begin
    logic [7:0]  d;
    logic [15:0] sp;
    rst_n = 1'b0; halt_i = 1'b0; pc_load_i = 1'b0; pc_val_i = '0; hi_first_i = 1'b0;
    len_we_i = 1'b0; len_addr_i = '0; len_code_i = '0; dispatch_i = 1'b0; nd_req_i = 1'b0;
    fetch_ack_i = 1'b0; fetch_data_i = '0;
    repeat (3) @(negedge clk);
    chk(!fetch_req_o && !cur_valid_o, "R10", int'(fetch_req_o), 0);
    chk(!disp_rdy_o && !nd_valid_o, "R10", int'(disp_rdy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fetch_req_o, "R10", int'(fetch_req_o), 0);

    // R1: fill the length table
    for (int op = 0; op < 256; op++) begin
      len_we_i = 1'b1; len_addr_i = 8'(op); len_code_i = lcode(8'(op));
      @(negedge clk);
    end
    len_we_i = 1'b0;

    // sweep of start addresses, byte orders and ack rates
    for (int hf = 0; hf < 2; hf++) begin
      for (int s = 0; s < 6; s++) begin
        case (s)
          0: sp = 16'h0000;
          1: sp = 16'h0001;
          2: sp = 16'h0102;
          3: sp = 16'h0203;
          4: sp = 16'hFFF1;
          default: sp = 16'h4567;
        endcase
        run_seq(sp, hf[0], 1 + ((s + hf) % 3), 12);
      end
    end

    // R5: operand not yet fetched
    hi_first_i = 1'b0; ack_period = 1; budget = 0;
    sp = 16'h0001;
    while (elen(bval(sp)) < 2) sp = sp + 16'd2;
    @(negedge clk);
    load_pc(sp);
    budget = 1;
    do_dispatch();
    repeat (3) @(negedge clk);
    chk(nd_valid_o == 1'b0, "R5", int'(nd_valid_o), 0);
    nd_req_i = 1'b1;
    @(negedge clk);
    nd_req_i = 1'b0;
    chk(nd_valid_o == 1'b0, "R5", int'(nd_valid_o), 0);
    budget = -1;
    nd_read(d);
    chk(d == bval(sp + 16'd1), "R5", int'(d), int'(bval(sp + 16'd1)));

    // R9: queue fills and requests stop
    load_pc(16'h0100);
    repeat (12) @(negedge clk);
    chk(fetch_req_o == 1'b0, "R9", int'(fetch_req_o), 0);
    chk(fetch_addr_o == 15'h0080 + 15'(DEPTH / 2), "R9", int'(fetch_addr_o), 16'h80 + DEPTH / 2);

    // R10: halt empties and stops
    do_dispatch();
    chk(cur_valid_o == 1'b1, "R2", int'(cur_valid_o), 1);
    halt_i = 1'b1;
    @(negedge clk);
    halt_i = 1'b0;
    chk(!fetch_req_o && !cur_valid_o, "R10", int'(cur_valid_o), 0);
    chk(!disp_rdy_o && !nd_valid_o, "R10", int'(disp_rdy_o), 0);
    repeat (5) @(negedge clk);
    chk(!fetch_req_o && !disp_rdy_o, "R10", int'(fetch_req_o), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule